// File: doc/BRIEF.md
# Timed Sleep and Power-Down Controller

This block sequences entry into and exit from two low-power states of a device controlled over a serial port. A write to its control word carries a duration in whole seconds together with a request for either sleep or power-down. The request does not act when it is written. It is held until the chip-select line returns high, which marks the end of the serial transaction. The controller then stays in the requested state for the programmed number of seconds. A duration of zero keeps it there until a wake event arrives.

A prescaler divides the system clock down to a one-second tick. The device wakes on any of three events: the countdown reaches its end, chip-select falls, or the reset input is driven low. Every return to the awake state produces a one-cycle wake pulse. A return from power-down also produces a one-cycle pulse that tells the rest of the device to restore its volatile configuration to defaults. Sleep keeps that configuration, so it produces no such pulse. Gating the clocks and switching the power rails are left to the surrounding logic.

Top module: `lp_timer_ctrl`

## Requirements
- R1: While and after reset, state_o is 0 (awake), and sleeping, powered_down, wake_pulse and clr_volatile are all 0.
- R2: A write with bit DUR_W (sleep) or bit DUR_W+1 (power-down) set moves the state from awake to pending (code 1). It never enters a low-power state directly.
- R3: In pending, the first rising edge of cs_n enters sleep (code 2) when only the sleep bit was written. It enters power-down (code 3) when the power-down bit was written. When both bits are written together, power-down wins.
- R4: With a nonzero duration D in bits [DUR_W-1:0], the low-power state lasts exactly D*CLKS_PER_SEC cycles. The state then returns to awake.
- R5: With a duration of 0, the low-power state persists with no time limit.
- R6: A falling edge of cs_n in sleep or power-down returns the state to awake in the following cycle.
- R7: Driving rst_n low in any state returns the block to awake at once.
- R8: wake_pulse is high for exactly one cycle, the first awake cycle after every exit from sleep or power-down, and is low at all other times.
- R9: clr_volatile is high for one cycle after an exit from power-down. It stays low after an exit from sleep.
- R10: A write with neither request bit set leaves the state awake. A cs_n rise in the awake state changes nothing. Writes made during sleep or power-down are ignored.
- R11: sleeping is high exactly in state 2, and powered_down is high exactly in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time base for the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset; also a wake source |
| cs_n | input | 1 | Serial chip-select, active low |
| wr_en | input | 1 | One-cycle strobe that writes the control word |
| wr_data | input | DUR_W+2 | Control word: duration [DUR_W-1:0], sleep request [DUR_W], power-down request [DUR_W+1] |
| state_o | output | 2 | Current state: 0 awake, 1 pending, 2 sleep, 3 power-down |
| sleeping | output | 1 | High while in sleep |
| powered_down | output | 1 | High while in power-down |
| wake_pulse | output | 1 | One-cycle pulse on each return to awake |
| clr_volatile | output | 1 | One-cycle pulse that restores volatile settings after power-down |

## Verification
The bench builds the block with CLKS_PER_SEC = 7 and the default 8-bit duration. A full second therefore takes only seven cycles, and random durations of up to a dozen seconds can run out to their natural expiry. Each timed stay can then be counted cycle by cycle against D*7, which also exposes off-by-one errors in the prescaler. With the same short tick, the bench can hold zero-duration stays for hundreds of cycles before it wakes them by chip-select or by reset.

// File: rtl/lp_timer_ctrl.sv
module lp_timer_ctrl #(
  parameter int CLKS_PER_SEC = 50_000_000,
  parameter int DUR_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_en,
  input  logic [DUR_W+1:0] wr_data,
  output logic [1:0]       state_o,
  output logic             sleeping,
  output logic             powered_down,
  output logic             wake_pulse,
  output logic             clr_volatile
);

  localparam int PW = (CLKS_PER_SEC > 2) ? $clog2(CLKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(CLKS_PER_SEC - 1);
  localparam int SLP_BIT = DUR_W;
  localparam int PD_BIT  = DUR_W + 1;

  localparam logic [1:0] ST_AWAKE = 2'd0;
  localparam logic [1:0] ST_PEND  = 2'd1;
  localparam logic [1:0] ST_SLEEP = 2'd2;
  localparam logic [1:0] ST_PDOWN = 2'd3;

  logic [1:0]       state;
  logic             cs_prev;
  logic             pd_req;
  logic [DUR_W-1:0] dur_q;
  logic [DUR_W-1:0] remain;
  logic [PW-1:0]    presc;

  wire cs_rise = cs_n & ~cs_prev;
  wire cs_fall = ~cs_n & cs_prev;
  wire low_pwr = state[1];
  wire tick    = low_pwr && (presc == PRESC_LAST);
  wire expire  = tick && (remain == DUR_W'(1));
  wire exit_lp = low_pwr && (cs_fall || expire);
  wire req_any = wr_en && (wr_data[SLP_BIT] || wr_data[PD_BIT]);

  assign state_o      = state;
  assign sleeping     = (state == ST_SLEEP);
  assign powered_down = (state == ST_PDOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_AWAKE;
      cs_prev      <= 1'b1;
      pd_req       <= 1'b0;
      dur_q        <= '0;
      remain       <= '0;
      presc        <= '0;
      wake_pulse   <= 1'b0;
      clr_volatile <= 1'b0;
    end else begin
      cs_prev      <= cs_n;
      wake_pulse   <= exit_lp;
      clr_volatile <= exit_lp && (state == ST_PDOWN);
      if (!low_pwr) begin
        if (wr_en) dur_q <= wr_data[DUR_W-1:0];
        if (req_any) begin
          pd_req <= wr_data[PD_BIT];
          state  <= ST_PEND;
        end else if (state == ST_PEND && cs_rise) begin
          state  <= pd_req ? ST_PDOWN : ST_SLEEP;
          remain <= dur_q;
          presc  <= '0;
          pd_req <= 1'b0;
        end
      end else if (exit_lp) begin
        state <= ST_AWAKE;
        if (state == ST_PDOWN) dur_q <= '0;
      end else begin
        presc <= tick ? '0 : presc + PW'(1);
        if (tick && remain != '0) remain <= remain - DUR_W'(1);
      end
    end
  end

endmodule

// File: rtl/lp_timer_ctrl_chk.sv
module lp_timer_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [1:0] state_o,
  input logic       sleeping,
  input logic       powered_down,
  input logic       wake_pulse,
  input logic       clr_volatile
);

  wire lp = (state_o == 2'd2) || (state_o == 2'd3);

  a_r2_no_direct_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |=> !lp);

  a_r6_cs_fall_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (lp && $fell(cs_n)) |=> (state_o == 2'd0));

  a_r8_wake_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> ((state_o == 2'd0) == wake_pulse));

  a_r8_no_stray_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !lp |=> !wake_pulse);

  a_r9_clr_after_pdown: assert property (@(posedge clk) disable iff (!rst_n)
    clr_volatile |-> ($past(state_o) == 2'd3));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleeping, powered_down}));

endmodule

bind lp_timer_ctrl lp_timer_ctrl_chk u_chk (.*);

// File: tb/lp_timer_ctrl_test.sv
module lp_timer_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPS = 7;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0, cs_n = 1, wr_en = 0;
  logic [DW+1:0] wr_data = '0;
  logic [1:0] state_o;
  logic sleeping, powered_down, wake_pulse, clr_volatile;
  int checks = 0, fails = 0;
  bit done = 0;

  lp_timer_ctrl #(.CLKS_PER_SEC(CPS), .DUR_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .wr_data(wr_data),
    .state_o(state_o), .sleeping(sleeping), .powered_down(powered_down),
    .wake_pulse(wake_pulse), .clr_volatile(clr_volatile));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_state(input logic [DW+1:0] d);
    return d[DW+1] ? 3 : 2;
  endfunction

  function automatic int exp_cycles(input logic [DW+1:0] d);
    return int'(d[DW-1:0]) * CPS;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic request(input logic [DW+1:0] d);
    @(negedge clk) cs_n = 0;
    @(negedge clk) begin wr_en = 1; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic enter(input logic [DW+1:0] d);
    request(d);
    chk(state_o == 2'd1, "R2 pending", state_o, 1);
    @(negedge clk) cs_n = 1;
    @(negedge clk);
    chk(state_o == 2'(exp_state(d)), "R3 entry", state_o, exp_state(d));
    chk(sleeping == (exp_state(d) == 2) && powered_down == (exp_state(d) == 3),
        "R11 flags", {sleeping, powered_down}, (exp_state(d) == 2) ? 2 : 1);
  endtask

  task automatic timed_run(input logic [DW+1:0] d);
    int cnt = 0;
    enter(d);
    while (state_o[1] && cnt < 100000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == exp_cycles(d), "R4 duration", cnt, exp_cycles(d));
    chk(wake_pulse == 1, "R8 pulse", wake_pulse, 1);
    chk(clr_volatile == (exp_state(d) == 3), "R9 clear", clr_volatile, exp_state(d) == 3);
    @(negedge clk);
    chk(wake_pulse == 0 && clr_volatile == 0, "R8 single cycle", wake_pulse, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h1A2B));
    repeat (3) @(negedge clk);
    chk(state_o == 0 && !sleeping && !powered_down && !wake_pulse && !clr_volatile,
        "R1 reset", state_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(state_o == 0 && !wake_pulse, "R1 after reset", state_o, 0);

    // R10: no request bits
    request(10'h005);
    chk(state_o == 0, "R10 plain write", state_o, 0);
    @(negedge clk) cs_n = 1;
    repeat (2) @(negedge clk);
    chk(state_o == 0, "R10 cs rise awake", state_o, 0);

    // R4 directed: 1 second, both bits -> power-down (R3)
    timed_run(10'h101);
    timed_run(10'h301);

    // R4 random
    for (int i = 0; i < 20; i++) begin
      logic [DW+1:0] d;
      d[DW-1:0] = DW'(1 + $urandom_range(0, 11));
      d[DW+1:DW] = 2'($urandom_range(1, 3));
      timed_run(d);
    end

    // R5 indefinite sleep, R10 ignored write, R6 wake by cs fall
    enter(10'h100);
    repeat (300) @(negedge clk);
    chk(state_o == 2, "R5 indefinite", state_o, 2);
    wr_en = 1; wr_data = 10'h204;
    @(negedge clk) wr_en = 0;
    repeat (2) @(negedge clk);
    chk(state_o == 2, "R10 write ignored", state_o, 2);
    cs_n = 0;
    @(negedge clk);
    chk(state_o == 0 && wake_pulse && !clr_volatile, "R6 cs wake sleep", state_o, 0);
    cs_n = 1;

    // R6 from power-down, with R9
    enter(10'h200);
    repeat (200) @(negedge clk);
    chk(state_o == 3, "R5 indefinite pdown", state_o, 3);
    cs_n = 0;
    @(negedge clk);
    chk(state_o == 0 && wake_pulse, "R6 cs wake pdown", state_o, 0);
    chk(clr_volatile == 1, "R9 clear on cs wake", clr_volatile, 1);
    cs_n = 1;

    // R7 reset wake
    enter(10'h200);
    repeat (20) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(state_o == 0 && !powered_down, "R7 reset wake", state_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(state_o == 0, "R7 stays awake", state_o, 0);

    finish_up();
  end
endmodule